// File: doc/BRIEF.md
# Control-Register Port Handshake Master

This block carries single register accesses from a host into the internal control-register port of a PHY. That port sees only one 16-bit input bus, a few command strobes and a single acknowledge line. The host presents an address, write data and a read/write select, then pulses `start`. The block splits the access into handshakes that run one after another. A write uses an address capture, then a data capture, then a write commit. A read uses an address capture, then a read. Each handshake is four-phase on the one acknowledge line.

Both halves of every handshake are bounded. The wait for acknowledge to rise and the wait for it to fall each last at most `POLL_LIMIT` polling intervals of `TICK_CYCLES` clocks. When either wait runs out, the transaction stops at once and the block reports an error. It reports success with a one-cycle `done` pulse. For a read, the returned word appears on `rdata`.

Top module: `cr_port_master`

## Requirements
- R1: A write issues exactly three handshakes, in this order: address capture with the address on the data field, data capture with the write data on the data field, and write commit.
- R2: The command word places address capture at bit 0, data capture at bit 1, the 16-bit data field at bits 17:2, read at bit 18 and write at bit 19. At most one command bit is high at a time.
- R3: In each handshake, the block raises the command bit with the data field already set and waits for acknowledge high. It then drops the command bit with the data field unchanged and waits for acknowledge low. A capture handshake is preceded by at least one cycle that shows its value on the data field with no command bit set.
- R4: The status word carries acknowledge at bit 0 and the returned 16-bit data at bits 16:1.
- R5: A read issues an address capture and then a read handshake. `rdata` takes the status data captured while acknowledge is high, so a read returns the last value written to that address.
- R6: A wait that sees no acknowledge change ends after exactly TICK_CYCLES*POLL_LIMIT cycles. For the wait for acknowledge high, `err` goes high that many cycles after the command bit first shows.
- R7: After a timeout, no later handshake of that transaction is issued, and all command bits are low.
- R8: `busy` is high from the cycle after an accepted `start` until the transaction ends. A `start` that arrives while busy is ignored and starts no access.
- R9: `done` is a one-cycle pulse, with `busy` already low in the same cycle. It is never high together with `err`.
- R10: A timeout gives a one-cycle `err` pulse and sets `err_flag`, which holds until the next accepted `start` clears it.
- R11: During and after reset, `busy`, `done`, `err`, `err_flag` and all command bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transaction when idle |
| rd_req | input | 1 | 1 selects a read, 0 a write |
| addr | input | 16 | Register address inside the PHY |
| wdata | input | 16 | Data for a write |
| cmd_word | output | 20 | Command word to the PHY port (layout in R2) |
| stat_word | input | 17 | Status word from the PHY port (layout in R4) |
| rdata | output | 16 | Data returned by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle timeout pulse |
| err_flag | output | 1 | Sticky timeout status |

## Verification
The hardest cases to reach are the two timeouts, because a well-behaved port never produces them. The worst is the one where acknowledge rises but never falls during the data capture, since the block must then give up while its command bit is already low. The bench's port model has fault modes for this. One never answers a command. The other latches acknowledge high once a data capture is seen. Short tick and poll parameters keep these waits to a few cycles, so the exact expiry cycle can be checked. The same model logs every command rise, checks that the data field stays stable, and checks that each command drop follows an acknowledge.

// File: rtl/cr_port_master.sv
module cr_port_master #(
  parameter int DW          = 16,
  parameter int TICK_CYCLES = 100,
  parameter int POLL_LIMIT  = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_req,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW+3:0] cmd_word,
  input  logic [DW:0]   stat_word,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          err_flag
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_REQ, S_REL} state_t;
  typedef enum logic [1:0] {P_ADDR, P_DATA, P_WR, P_RD} phase_t;

  state_t        state;
  phase_t        phase;
  logic [DW-1:0] din_q, wd_q;
  logic          rd_q;
  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;
  logic          ack, req_on, hit, tick_end, expire;

  assign ack      = stat_word[0];
  assign req_on   = state == S_REQ;
  assign hit      = req_on ? ack : !ack;
  assign tick_end = tick_q == TW'(TICK_CYCLES - 1);
  assign expire   = (req_on || state == S_REL) && !hit && tick_end &&
                    poll_q == PW'(POLL_LIMIT - 1);
  assign busy     = state != S_IDLE;

  assign cmd_word = {req_on && phase == P_WR, req_on && phase == P_RD, din_q,
                     req_on && phase == P_DATA, req_on && phase == P_ADDR};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= P_ADDR;
      din_q    <= '0;
      wd_q     <= '0;
      rd_q     <= 1'b0;
      rdata    <= '0;
      tick_q   <= '0;
      poll_q   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          din_q    <= addr;
          wd_q     <= wdata;
          rd_q     <= rd_req;
          phase    <= P_ADDR;
          state    <= S_SETUP;
          err_flag <= 1'b0;
        end
        S_SETUP: begin
          tick_q <= '0;
          poll_q <= '0;
          state  <= S_REQ;
        end
        default: begin
          if (expire) begin
            state    <= S_IDLE;
            err      <= 1'b1;
            err_flag <= 1'b1;
          end else if (hit) begin
            tick_q <= '0;
            poll_q <= '0;
            if (req_on) begin
              state <= S_REL;
              if (phase == P_RD) rdata <= stat_word[DW:1];
            end else begin
              case (phase)
                P_ADDR: if (rd_q) begin
                  phase <= P_RD;
                  state <= S_REQ;
                end else begin
                  phase <= P_DATA;
                  din_q <= wd_q;
                  state <= S_SETUP;
                end
                P_DATA: begin
                  phase <= P_WR;
                  state <= S_REQ;
                end
                default: begin
                  state <= S_IDLE;
                  done  <= 1'b1;
                end
              endcase
            end
          end else begin
            tick_q <= tick_end ? '0 : tick_q + 1'b1;
            if (tick_end) poll_q <= poll_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cr_port_master_chk.sv
module cr_port_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW+3:0] cmd_word,
  input logic          ack,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          err_flag
);
  logic [3:0]    cmds;
  logic [DW-1:0] din;
  assign cmds = {cmd_word[DW+3], cmd_word[DW+2], cmd_word[1], cmd_word[0]};
  assign din  = cmd_word[DW+1:2];

  a_r2_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmds));

  a_r3_din_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmds != 4'd0 && $past(cmds) != 4'd0) |-> $stable(din));

  a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmds) != 4'd0 && cmds == 4'd0 && !err) |-> $past(ack));

  a_r8_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  a_r10_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_flag);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmds == 4'd0);
endmodule

bind cr_port_master cr_port_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
  .ack(stat_word[0]), .busy(busy), .done(done), .err(err), .err_flag(err_flag)
);

// File: tb/sim_cr_port_master.sv
module sim_cr_port_master;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;
  localparam int LIMIT = 4;
  localparam int DLY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_req = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [19:0] cmd_word;
  logic [16:0] stat_word;
  logic [15:0] rdata;
  logic busy, done, err, err_flag;

  int checks = 0, failures = 0, cyc = 0;

  cr_port_master #(.DW(16), .TICK_CYCLES(TICK), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .addr(addr),
    .wdata(wdata), .cmd_word(cmd_word), .stat_word(stat_word), .rdata(rdata),
    .busy(busy), .done(done), .err(err), .err_flag(err_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY port model: mode 0 normal, 1 never acknowledges, 2 ack sticks high after data capture
  int mode = 0;
  logic ack_m, stuck, prev_ack;
  logic [1:0] dly;
  logic [15:0] mem [16];
  logic [15:0] cap_a, cap_d, prev_din;
  logic [3:0] prev_cmds;
  int viol, ev_n;
  int ev [256];
  wire [3:0] cmds = {cmd_word[19], cmd_word[18], cmd_word[1], cmd_word[0]};
  wire [15:0] din = cmd_word[17:2];
  assign stat_word = {mem[cap_a[3:0]], ack_m};

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_m <= 1'b0; stuck <= 1'b0; dly <= '0; cap_a <= '0; cap_d <= '0;
      prev_cmds <= '0; prev_ack <= 1'b0; prev_din <= '0; viol <= 0; ev_n <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (mode != 2) stuck <= 1'b0;
      if (stuck) ack_m <= 1'b1;
      else if ((cmds != 4'd0) != ack_m) begin
        if (dly == 2'(DLY - 1)) begin
          dly <= '0;
          if (!(mode == 1 && cmds != 4'd0)) ack_m <= (cmds != 4'd0);
          if (mode == 2 && cmds[1]) stuck <= 1'b1;
        end else dly <= dly + 1'b1;
      end else dly <= '0;

      if (prev_cmds == 4'd0 && cmds != 4'd0) begin
        ev[ev_n % 256] <= cmds[0] ? 1 : cmds[1] ? 2 : cmds[2] ? 3 : 4;
        ev_n <= ev_n + 1;
        if (cmds[0]) cap_a <= din;
        if (cmds[1]) cap_d <= din;
        if (cmds[3]) mem[cap_a[3:0]] <= cap_d;
        if ((cmds[0] || cmds[1]) && din != prev_din) viol <= viol + 1;
        if (prev_ack && mode == 0) viol <= viol + 1;
      end
      if (prev_cmds != 4'd0 && cmds != 4'd0 && din != prev_din) viol <= viol + 1;
      if (prev_cmds != 4'd0 && cmds == 4'd0 && !prev_ack && mode == 0) viol <= viol + 1;
      prev_cmds <= cmds; prev_ack <= ack_m; prev_din <= din;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit t_done, t_err, busy_seen;
  int t_lat;

  task automatic run_txn(input bit rd, input logic [15:0] a, input logic [15:0] d);
    int n = 0, t0 = -1;
    @(negedge clk);
    start = 1'b1; rd_req = rd; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    busy_seen = busy;
    while (!done && !err && n < 300) begin
      @(negedge clk);
      n++;
      if (t0 < 0 && cmds != 4'd0) t0 = n;
    end
    t_done = done; t_err = err; t_lat = n - t0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {rd, addr, data}
  localparam logic [32:0] VEC [9] = '{
    {1'b0, 16'h0003, 16'hA5C3}, {1'b0, 16'h0009, 16'h1234}, {1'b1, 16'h0003, 16'h0000},
    {1'b0, 16'h000F, 16'hFFFF}, {1'b1, 16'h0009, 16'h0000}, {1'b0, 16'h0003, 16'h0001},
    {1'b1, 16'h0003, 16'h0000}, {1'b1, 16'h000F, 16'h0000}, {1'b1, 16'h0000, 16'h0000}};

  logic [15:0] shadow [16];

  initial begin
    int base;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !err_flag && cmds == 0, "R11", "outputs in reset", {busy, done, err, err_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !err_flag && cmds == 0, "R11", "outputs after reset", {busy, done, err, err_flag}, 0);

    for (int k = 0; k < 9; k++) begin
      logic vr; logic [15:0] va, vd;
      {vr, va, vd} = VEC[k];
      base = ev_n;
      run_txn(vr, va, vd);
      chk(t_done && !t_err, "R9", "done without error", {t_done, t_err}, 2);
      chk(busy_seen, "R8", "busy after start", busy_seen, 1);
      chk(!busy, "R9", "busy low with done", busy, 0);
      if (!vr) begin
        shadow[va[3:0]] = vd;
        chk(ev_n == base + 3, "R1", "write handshake count", ev_n - base, 3);
        chk(ev[base % 256] == 1 && ev[(base+1) % 256] == 2 && ev[(base+2) % 256] == 4, "R1",
            "write order addr,data,commit (R2 bits 0,1,19)",
            ev[base % 256]*100 + ev[(base+1) % 256]*10 + ev[(base+2) % 256], 124);
        chk(mem[va[3:0]] == vd, "R1", "port register written", mem[va[3:0]], vd);
      end else begin
        chk(ev_n == base + 2, "R5", "read handshake count", ev_n - base, 2);
        chk(ev[base % 256] == 1 && ev[(base+1) % 256] == 3, "R5", "read order addr,read (R2 bit 18)",
            ev[base % 256]*10 + ev[(base+1) % 256], 13);
        chk(rdata == shadow[va[3:0]], "R5", "read data via R4 bits 16:1", rdata, shadow[va[3:0]]);
      end
      @(negedge clk);
      chk(!done, "R9", "done lasts one cycle", done, 0);
    end
    chk(viol == 0, "R3", "handshake protocol violations", viol, 0);

    // start while busy is ignored
    base = ev_n;
    @(negedge clk);
    start = 1'b1; rd_req = 1'b0; addr = 16'h0005; wdata = 16'h0BEE;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(busy, "R8", "busy before second start", busy, 1);
    start = 1'b1; addr = 16'h0006; wdata = 16'h0BAD;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(!busy && ev_n == base + 3, "R8", "no second transaction", ev_n - base, 3);
    chk(mem[5] == 16'h0BEE, "R8", "first write kept", mem[5], 16'h0BEE);
    chk(mem[6] == 16'h0000, "R8", "ignored write absent", mem[6], 0);

    // timeout waiting for ack high
    mode = 1;
    base = ev_n;
    run_txn(1'b0, 16'h0002, 16'h7777);
    chk(t_err && !t_done, "R10", "error pulse on timeout", {t_err, t_done}, 2);
    chk(t_lat == TICK * LIMIT, "R6", "cycles to timeout", t_lat, TICK * LIMIT);
    chk(err_flag, "R10", "sticky flag set", err_flag, 1);
    @(negedge clk);
    chk(!err && err_flag, "R10", "pulse ends, flag holds", {err, err_flag}, 1);
    repeat (20) @(negedge clk);
    chk(ev_n == base + 1 && cmds == 0, "R7", "no phase after address timeout", ev_n - base, 1);
    chk(mem[2] == 16'h0000, "R7", "no write after timeout", mem[2], 0);

    // timeout waiting for ack low during data capture
    mode = 0;
    repeat (6) @(negedge clk);
    mode = 2;
    base = ev_n;
    run_txn(1'b0, 16'h0004, 16'h4444);
    chk(t_err && !t_done, "R6", "release wait times out", {t_err, t_done}, 2);
    repeat (20) @(negedge clk);
    chk(ev_n == base + 2 && ev[(base+1) % 256] == 2, "R7", "commit not issued", ev_n - base, 2);
    chk(mem[4] == 16'h0000 && cmds == 0, "R7", "nothing committed", mem[4], 0);

    // next accepted start clears the flag
    mode = 0;
    repeat (6) @(negedge clk);
    @(negedge clk);
    start = 1'b1; rd_req = 1'b0; addr = 16'h0008; wdata = 16'h5A5A;
    @(negedge clk);
    start = 1'b0;
    chk(!err_flag && busy, "R10", "flag cleared by start", err_flag, 0);
    while (!done && !err) @(negedge clk);
    chk(done && mem[8] == 16'h5A5A, "R1", "write after recovery", mem[8], 16'h5A5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule